// File: doc/BRIEF.md
# DDR-II SRAM Burst Controller

This block sits between a simple request stream and a double-data-rate-II synchronous SRAM. Each user request carries one whole burst: a read/write flag, a burst address, a user word holding every beat of the burst, and one byte-enable bit per byte. The block turns it into the command, address, byte-select and data timing the memory expects, and it collects the read beats that come back. A parameter selects burst-of-2 or burst-of-4 devices.

Every double-data-rate pin appears as two single-rate halves. The rising half is the value for the K (or C) rising edge of a cycle. The falling half is the value for the Kn (or Cn) rising edge in the middle of that cycle. This is how an I/O DDR register pair presents the pins, so the whole design runs on one clock. The controller treats the data bus as shared by reads and writes, as on common-I/O parts, and never lets two bursts claim the same half-cycle.

The request interface is valid/ready. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. While `req_valid` is high and `req_ready` is low, the user holds every request field stable. `req_ready` depends on the current `req_write` and on internal state, never on `req_valid`. Read results come out on a single-cycle `rd_valid` strobe, with no back-pressure.

Top module: `ddr2b_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, `mem_ld_n` is high, every lane of both byte-select groups is high, `rd_valid` is low and `req_ready` is high.
- R2: A request accepted at a rising edge drives `mem_ld_n` low for exactly the next cycle. In that cycle `mem_addr` equals the request address and `mem_rw` is 1 for a read and 0 for a write. On every other cycle `mem_ld_n` stays high.
- R3: If a write command is on the pins in cycle t, beat k (user bits [k*W +: W], beat 0 lowest) appears on `mem_d_rise` in cycle t+1+k/2 when k is even, and on `mem_d_fall` in that cycle when k is odd.
- R4: In the half-cycle carrying write beat k, byte-select lane j (active low) is 0 exactly when `req_be` bit k*W/8+j was 1. Outside write data half-cycles, all lanes of both groups are 1.
- R5: If a read command is on the pins in cycle t, beat k is taken from half-cycle 3+k counted from the address edge. When 3+k is odd it is `mem_q_fall` of cycle t+(3+k)/2; when 3+k is even it is `mem_q_rise` of that cycle. `rd_valid` is high for the single cycle t+2+BURST/2, and beat k sits at `rd_data` bits [k*W +: W].
- R6: `req_ready` is low exactly when the data half-cycles of the presented request overlap those of an earlier burst. A write uses half-cycles 2..1+BURST after its address edge; a read uses 3..2+BURST. With BURST=4, a write must follow a read by three cycles. With BURST=2, it must follow by two cycles. Every other pairing may follow as closely as the bus allows.
- R7: With BURST=4, requests are never accepted in two adjacent cycles.
- R8: A request held while `req_ready` is low causes no command on the pins, and it is issued unchanged on the cycle after it is finally accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (K-rate) |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | Burst address |
| req_wdata | input | BURST*WORD_W | Write beats, beat 0 in the low bits |
| req_be | input | BURST*WORD_W/8 | Byte enables, active high |
| rd_valid | output | 1 | One-cycle strobe for a completed read |
| rd_data | output | BURST*WORD_W | Read beats, beat 0 in the low bits |
| mem_ld_n | output | 1 | Load strobe, active low |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | ADDR_W | Memory address |
| mem_bws_rise_n | output | WORD_W/8 | Byte selects for the K-edge beat, active low |
| mem_bws_fall_n | output | WORD_W/8 | Byte selects for the Kn-edge beat, active low |
| mem_d_rise | output | WORD_W | Write beat for the K edge |
| mem_d_fall | output | WORD_W | Write beat for the Kn edge |
| mem_q_rise | input | WORD_W | Read beat captured on the C edge |
| mem_q_fall | input | WORD_W | Read beat captured on the Cn edge |

## Verification
The block is driven with several request patterns:
- An isolated write followed later by a read of the same address, to check beat placement on both halves and the read capture latency.
- Partial byte enables, so lane polarity and per-beat lane mapping show up in the data read back.
- Back-to-back streams of one direction, and write-then-read pairs, which exercise the closest legal spacing.
- Read-then-write pairs, which must stall for a cycle or more.
- A long pseudo-random mix with random gaps and narrow address reuse, which catches collisions between overlapping bursts and stale capture slots.

A behavioural memory answers on the read pins and receives beats only from the write pins, so any timing slip surfaces as wrong data.

// File: rtl/ddr2b_pkg.sv
`timescale 1ns/1ps
package ddr2b_pkg;

  // Direction encoding on the memory R/W pin.
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } dir_e;

  // Half-cycle index, counted from the address edge, at which beat `beat`
  // of a burst travels on the shared data bus.
  function automatic int beat_half(input int beat, input bit is_read);
    return is_read ? (3 + beat) : (2 + beat);
  endfunction

endpackage

// File: rtl/ddr2b_slot_guard.sv
`timescale 1ns/1ps
module ddr2b_slot_guard #(
  parameter int BURST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_write,
  input  logic accept,
  output logic ready
);
  localparam int MW = 3 + BURST;

  function automatic logic [MW-1:0] span_of(input bit rd);
    logic [MW-1:0] m;
    m = '0;
    for (int k = 0; k < BURST; k++) m[ddr2b_pkg::beat_half(k, rd)] = 1'b1;
    return m;
  endfunction

  localparam logic [MW-1:0] WR_SPAN = span_of(1'b0);
  localparam logic [MW-1:0] RD_SPAN = span_of(1'b1);

  // Bit j: half-cycle j after the address edge of a request taken now is busy.
  logic [MW-1:0] resv;
  logic [MW-1:0] claim;

  assign claim = req_write ? WR_SPAN : RD_SPAN;
  assign ready = (resv & claim) == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resv <= '0;
    else        resv <= (resv | (accept ? claim : '0)) >> 2;
  end

  generate
    if (BURST == 4) begin : g_b4
      // R7: reservation alone must keep burst-of-4 commands apart
      assert_b4_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
    end
  endgenerate

endmodule

// File: rtl/ddr2b_cmd_issue.sv
`timescale 1ns/1ps
module ddr2b_cmd_issue #(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 16,
  parameter int BURST  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accept,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [BURST*WORD_W-1:0]     req_wdata,
  input  logic [BURST*WORD_W/8-1:0]   req_be,
  output logic                        mem_ld_n,
  output logic                        mem_rw,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [WORD_W/8-1:0]         mem_bws_rise_n,
  output logic [WORD_W/8-1:0]         mem_bws_fall_n,
  output logic [WORD_W-1:0]           mem_d_rise,
  output logic [WORD_W-1:0]           mem_d_fall,
  output logic                        rd_issued
);
  import ddr2b_pkg::*;

  localparam int BW    = WORD_W / 8;
  localparam int UW    = BURST * WORD_W;
  localparam int UBW   = BURST * BW;
  localparam int PAIRS = BURST / 2;
  localparam int CW    = $clog2(PAIRS + 1);

  logic              ld_n_q;
  dir_e              dir_q;
  logic [ADDR_W-1:0] addr_q;
  logic [UW-1:0]     wdat_q;
  logic [UBW-1:0]    be_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_n_q <= 1'b1;
      dir_q  <= DIR_READ;
      addr_q <= '0;
      wdat_q <= '0;
      be_q   <= '0;
    end else begin
      ld_n_q <= !accept;
      if (accept) begin
        dir_q  <= req_write ? DIR_WRITE : DIR_READ;
        addr_q <= req_addr;
        wdat_q <= req_wdata;
        be_q   <= req_be;
      end
    end
  end

  logic wr_now;
  assign wr_now    = !ld_n_q && (dir_q == DIR_WRITE);
  assign rd_issued = !ld_n_q && (dir_q == DIR_READ);

  // Write beat shifter: one rise/fall pair leaves per cycle.
  logic [UW-1:0]  wsh;
  logic [UBW-1:0] bsh;
  logic [CW-1:0]  wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsh  <= '0;
      bsh  <= '0;
      wcnt <= '0;
    end else if (wr_now) begin
      wsh  <= wdat_q;
      bsh  <= be_q;
      wcnt <= CW'(PAIRS);
    end else if (wcnt != '0) begin
      wsh  <= wsh >> (2 * WORD_W);
      bsh  <= bsh >> (2 * BW);
      wcnt <= wcnt - 1'b1;
    end
  end

  assign mem_ld_n       = ld_n_q;
  assign mem_rw         = dir_q;
  assign mem_addr       = addr_q;
  assign mem_d_rise     = wsh[WORD_W-1:0];
  assign mem_d_fall     = wsh[2*WORD_W-1:WORD_W];
  assign mem_bws_rise_n = (wcnt != '0) ? ~bsh[BW-1:0]      : '1;
  assign mem_bws_fall_n = (wcnt != '0) ? ~bsh[2*BW-1:BW]   : '1;

  // R4: the cycle after a read command carries no write beat
  assert_read_quiets_bws_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issued |=> ((&mem_bws_rise_n) && (&mem_bws_fall_n)));

endmodule

// File: rtl/ddr2b_read_gather.sv
`timescale 1ns/1ps
module ddr2b_read_gather #(
  parameter int WORD_W = 16,
  parameter int BURST  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_issued,
  input  logic [WORD_W-1:0]       q_rise,
  input  logic [WORD_W-1:0]       q_fall,
  output logic                    rd_valid,
  output logic [BURST*WORD_W-1:0] rd_data
);
  localparam int UW   = BURST * WORD_W;
  localparam int LAST = ddr2b_pkg::beat_half(BURST - 1, 1'b1) / 2;

  // trk[j]: a read address was on the pins j cycles ago.
  logic [LAST:1] trk;
  logic [UW-1:0] gathered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trk <= '0;
    else        trk <= {trk[LAST-1:1], rd_issued};
  end

  for (genvar k = 0; k < BURST - 1; k++) begin : g_beat
    localparam int H  = ddr2b_pkg::beat_half(k, 1'b1);
    localparam int CY = H / 2;
    logic [WORD_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (trk[CY]) slot <= (H % 2 == 1) ? q_fall : q_rise;
    end
    assign gathered[k*WORD_W +: WORD_W] = slot;
  end

  // The final beat always lands on a rising half and is taken live.
  assign gathered[(BURST-1)*WORD_W +: WORD_W] = q_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= trk[LAST];
      if (trk[LAST]) rd_data <= gathered;
    end
  end

  // R5: a result appears exactly LAST+1 cycles after each read command
  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(rd_issued, LAST + 1));

endmodule

// File: rtl/ddr2b_ctrl.sv
`timescale 1ns/1ps
module ddr2b_ctrl #(
  parameter int ADDR_W = 18,
  parameter int WORD_W = 16,
  parameter int BURST  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [BURST*WORD_W-1:0]     req_wdata,
  input  logic [BURST*WORD_W/8-1:0]   req_be,
  output logic                        rd_valid,
  output logic [BURST*WORD_W-1:0]     rd_data,
  output logic                        mem_ld_n,
  output logic                        mem_rw,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [WORD_W/8-1:0]         mem_bws_rise_n,
  output logic [WORD_W/8-1:0]         mem_bws_fall_n,
  output logic [WORD_W-1:0]           mem_d_rise,
  output logic [WORD_W-1:0]           mem_d_fall,
  input  logic [WORD_W-1:0]           mem_q_rise,
  input  logic [WORD_W-1:0]           mem_q_fall
);
  logic accept;
  logic rd_issued;

  assign accept = req_valid && req_ready;

  ddr2b_slot_guard #(.BURST(BURST)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_write (req_write),
    .accept    (accept),
    .ready     (req_ready)
  );

  ddr2b_cmd_issue #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BURST(BURST)) u_issue (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept         (accept),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .req_be         (req_be),
    .mem_ld_n       (mem_ld_n),
    .mem_rw         (mem_rw),
    .mem_addr       (mem_addr),
    .mem_bws_rise_n (mem_bws_rise_n),
    .mem_bws_fall_n (mem_bws_fall_n),
    .mem_d_rise     (mem_d_rise),
    .mem_d_fall     (mem_d_fall),
    .rd_issued      (rd_issued)
  );

  ddr2b_read_gather #(.WORD_W(WORD_W), .BURST(BURST)) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_issued (rd_issued),
    .q_rise    (mem_q_rise),
    .q_fall    (mem_q_fall),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  // R2: an accepted request shows up on the pins one cycle later
  assert_issue_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!mem_ld_n && mem_addr == $past(req_addr)));

  // R6: a write can never be taken right after a read
  assert_read_then_write_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> !(req_write && req_ready));

endmodule

// File: tb/sim_ddr2b_ctrl.sv
`timescale 1ns/1ps
module sim_ddr2b_ctrl;
  localparam int AW = 18;
  localparam int W  = 16;
  localparam int B  = 4;
  localparam int BW = W / 8;
  localparam int UW = B * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [UW-1:0] req_wdata = '0;
  logic [B*BW-1:0] req_be = '0;
  logic          rd_valid;
  logic [UW-1:0] rd_data;
  logic          mem_ld_n, mem_rw;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_bws_rise_n, mem_bws_fall_n;
  logic [W-1:0]  mem_d_rise, mem_d_fall;
  logic [W-1:0]  mem_q_rise = '0, mem_q_fall = '0;

  ddr2b_ctrl #(.ADDR_W(AW), .WORD_W(W), .BURST(B)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ld_n(mem_ld_n), .mem_rw(mem_rw),
    .mem_addr(mem_addr), .mem_bws_rise_n(mem_bws_rise_n), .mem_bws_fall_n(mem_bws_fall_n),
    .mem_d_rise(mem_d_rise), .mem_d_fall(mem_d_fall),
    .mem_q_rise(mem_q_rise), .mem_q_fall(mem_q_fall));

  typedef struct packed {
    logic          v;
    logic          w;
    logic [AW-1:0] a;
    logic [UW-1:0] d;
    logic [B*BW-1:0] be;
  } stim_t;

  int checks = 0, errors = 0, cyc = 0;
  bit running = 0, need_new = 1, finished = 0;
  int last_acc = -10;
  stim_t q_stim[$];
  stim_t cur;

  // reference expectations keyed by cycle
  bit          e_ld[int];
  bit          e_rw[int];
  logic [AW-1:0] e_addr[int];
  logic [W-1:0]  e_dr[int], e_df[int];
  logic [BW-1:0] e_br[int], e_bf[int];
  logic [UW-1:0] e_rd[int];
  bit          busy[int];
  logic [UW-1:0] refm[int];
  // pin-side memory model
  logic [UW-1:0] pmem[int];
  logic [AW-1:0] w_at[int];
  int            w_pair[int];
  logic [W-1:0]  qr_s[int], qf_s[int];

  function automatic logic [UW-1:0] init_word(input logic [AW-1:0] a);
    return {16'hC0DE, 16'h1234 ^ a[15:0], 16'h5A00 | a[7:0], a[15:0]};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [UW-1:0] act,
                     input logic [UW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  logic [UW-1:0] wtmp;
  logic [AW-1:0] atmp;
  bit            exp_r;
  int            t_cmd;

  always @(negedge clk) begin
    if (running) begin
      // --- compare registered outputs with the reference ---
      chk(mem_ld_n === !e_ld.exists(cyc), "R2 R8", UW'(mem_ld_n), UW'(!e_ld.exists(cyc)));
      if (e_ld.exists(cyc)) begin
        chk(mem_rw === e_rw[cyc], "R2", UW'(mem_rw), UW'(e_rw[cyc]));
        chk(mem_addr === e_addr[cyc], "R2", UW'(mem_addr), UW'(e_addr[cyc]));
      end
      chk(mem_bws_rise_n === (e_br.exists(cyc) ? e_br[cyc] : '1), "R4",
          UW'(mem_bws_rise_n), UW'(e_br.exists(cyc) ? e_br[cyc] : '1));
      chk(mem_bws_fall_n === (e_bf.exists(cyc) ? e_bf[cyc] : '1), "R4",
          UW'(mem_bws_fall_n), UW'(e_bf.exists(cyc) ? e_bf[cyc] : '1));
      if (e_dr.exists(cyc)) chk(mem_d_rise === e_dr[cyc], "R3", UW'(mem_d_rise), UW'(e_dr[cyc]));
      if (e_df.exists(cyc)) chk(mem_d_fall === e_df[cyc], "R3", UW'(mem_d_fall), UW'(e_df[cyc]));
      chk(rd_valid === e_rd.exists(cyc), "R5", UW'(rd_valid), UW'(e_rd.exists(cyc)));
      if (e_rd.exists(cyc)) chk(rd_data === e_rd[cyc], "R5", rd_data, e_rd[cyc]);

      // --- memory model: write beats from the pins, then new commands ---
      if (w_at.exists(cyc)) begin
        atmp = w_at[cyc];
        wtmp = pmem.exists(atmp) ? pmem[atmp] : init_word(atmp);
        for (int j = 0; j < BW; j++) begin
          if (!mem_bws_rise_n[j]) wtmp[(2*w_pair[cyc])*W + 8*j +: 8] = mem_d_rise[8*j +: 8];
          if (!mem_bws_fall_n[j]) wtmp[(2*w_pair[cyc]+1)*W + 8*j +: 8] = mem_d_fall[8*j +: 8];
        end
        pmem[atmp] = wtmp;
      end
      if (mem_ld_n === 1'b0) begin
        if (mem_rw === 1'b0) begin
          for (int j = 0; j < B/2; j++) begin
            w_at[cyc+1+j] = mem_addr;
            w_pair[cyc+1+j] = j;
          end
        end else begin
          wtmp = pmem.exists(mem_addr) ? pmem[mem_addr] : init_word(mem_addr);
          for (int k = 0; k < B; k++) begin
            if ((3 + k) % 2 == 1) qf_s[cyc + (3+k)/2] = wtmp[k*W +: W];
            else                  qr_s[cyc + (3+k)/2] = wtmp[k*W +: W];
          end
        end
      end
      mem_q_rise = qr_s.exists(cyc) ? qr_s[cyc] : (16'hBAD0 ^ W'(cyc));
      mem_q_fall = qf_s.exists(cyc) ? qf_s[cyc] : (16'h0DAB ^ W'(cyc));

      // --- stimulus: hold a stalled request, else take the next one ---
      if (need_new) begin
        if (q_stim.size() > 0) cur = q_stim.pop_front();
        else cur = '0;
        need_new = 0;
      end
      req_valid = cur.v; req_write = cur.w; req_addr = cur.a;
      req_wdata = cur.d; req_be = cur.be;
      if (!cur.v) need_new = 1;

      #1;
      // R6: ready predicted from busy half-cycles of earlier bursts
      exp_r = 1;
      for (int k = 0; k < B; k++)
        if (busy.exists(2*(cyc+1) + (req_write ? 2 + k : 3 + k))) exp_r = 0;
      chk(req_ready === exp_r, "R6", UW'(req_ready), UW'(exp_r));

      if (req_valid && req_ready) begin
        chk(cyc - last_acc >= 2, "R7", UW'(cyc - last_acc), UW'(2));
        last_acc = cyc;
        need_new = 1;
        t_cmd = cyc + 1;
        e_ld[t_cmd] = 1; e_rw[t_cmd] = !cur.w; e_addr[t_cmd] = cur.a;
        for (int k = 0; k < B; k++) busy[2*t_cmd + (cur.w ? 2 + k : 3 + k)] = 1;
        wtmp = refm.exists(cur.a) ? refm[cur.a] : init_word(cur.a);
        if (cur.w) begin
          for (int k = 0; k < B; k++) begin
            if (k % 2 == 0) begin
              e_dr[t_cmd+1+k/2] = cur.d[k*W +: W]; e_br[t_cmd+1+k/2] = ~cur.be[k*BW +: BW];
            end else begin
              e_df[t_cmd+1+k/2] = cur.d[k*W +: W]; e_bf[t_cmd+1+k/2] = ~cur.be[k*BW +: BW];
            end
            for (int j = 0; j < BW; j++)
              if (cur.be[k*BW+j]) wtmp[k*W + 8*j +: 8] = cur.d[k*W + 8*j +: 8];
          end
          refm[cur.a] = wtmp;
        end else begin
          e_rd[t_cmd + 2 + B/2] = wtmp;
        end
      end
    end
  end

  task automatic push(input bit v, input bit w, input int a, input logic [UW-1:0] d,
                      input logic [B*BW-1:0] be);
    stim_t s;
    s.v = v; s.w = w; s.a = AW'(a); s.d = d; s.be = be;
    q_stim.push_back(s);
  endtask

  int unsigned seed = 32'h1357_9BDF;
  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(mem_ld_n === 1'b1, "R1", UW'(mem_ld_n), 1);
    chk(&mem_bws_rise_n && &mem_bws_fall_n, "R1", UW'({mem_bws_rise_n, mem_bws_fall_n}), '1);
    chk(rd_valid === 1'b0, "R1", UW'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ld_n === 1'b1 && rd_valid === 1'b0, "R1", UW'({mem_ld_n, rd_valid}), 2);
    chk(req_ready === 1'b1, "R1", UW'(req_ready), 1);

    // R3 R5: lone write, later read
    push(1, 1, 5, 64'h1111_2222_3333_4444, '1);
    repeat (4) push(0, 0, 0, '0, '0);
    push(1, 0, 5, '0, '0);
    repeat (6) push(0, 0, 0, '0, '0);
    // R4: partial lanes then read
    push(1, 1, 5, 64'hAAAA_BBBB_CCCC_DDDD, 8'b1001_0110);
    push(1, 0, 5, '0, '0);
    // R7: same-direction streams
    for (int i = 0; i < 4; i++) push(1, 1, 8 + i, {4{16'(i * 16'h0101 + 16'h0F0F)}}, '1);
    for (int i = 0; i < 4; i++) push(1, 0, 8 + i, '0, '0);
    // R6 R8: read then write stalls
    push(1, 0, 9, '0, '0);
    push(1, 1, 9, 64'hFEED_FACE_DEAD_BEEF, 8'hF0);
    push(1, 0, 9, '0, '0);
    repeat (3) push(0, 0, 0, '0, '0);
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      if (rnd() % 4 == 0) push(0, 0, 0, '0, '0);
      push(1, rnd() % 2, rnd() % 8, {rnd(), rnd()}, 8'(rnd()));
    end

    running = 1;
    wait (q_stim.size() == 0 && need_new);
    repeat (12) @(negedge clk);
    running = 0;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule